// File: doc/BRIEF.md
# Vsync-Committed Shadow Register Bank

This block holds the per-window configuration registers of a display pipeline in two copies. A CPU write port only ever touches the shadow copy. The active copy, which feeds the scan-out logic, is refreshed from the shadow only at a vsync pulse. The refresh happens only after software has armed an update request by writing the control word. Each window has a protect input. While protect is high, none of that window's registers are copied, so a configuration that is only partly written can never reach the display.

The flow from software is as follows. Raise protect on every window, write the window registers, write the request bit, then drop protect. At the first vsync where a window has pending writes and is unprotected, all of that window's registers move to the active set together. A window still held by protect keeps its pending flag. The request stays armed until a vsync finds no window that is both pending and protected. The request is tracked by a three-state machine:

- `UPD_IDLE`: nothing requested.
- `UPD_ARMED`: request written, and no vsync has blocked it yet.
- `UPD_BLOCKED`: request still armed after a vsync at which a protected window kept it waiting.

The state transitions are:

- IDLE→ARMED on a request write.
- ARMED or BLOCKED→IDLE on a vsync that leaves nothing protected and pending.
- ARMED→BLOCKED on a vsync at which some pending window is protected.
- BLOCKED→ARMED on a request write coinciding with a vsync.
- Otherwise each state holds.

Reads return shadow values. The whole active set is exposed on a flat debug output, and bit 0 of each window's register 0 drives that window's enable output.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, all shadow and active registers are zero, no window is pending, and the control word reads zero.
- R2: A write to address `{1'b0, window, index}` updates that shadow register at once, so it reads back on the next cycle. The active registers do not change until a commit.
- R3: The active registers change only on a cycle where vsync is high while the update request is armed. A vsync with no request copies nothing.
- R4: Writing the control address (`cpu_addr` MSB = 1) with data bit 0 = 1 arms the request. A control read returns bit 0 = armed and bits [NUM_WIN:1] = per-window pending flags. The request disarms after a vsync at which no pending window is protected.
- R5: While `win_protect[w]` is high, no register of window w is copied at vsync, and its pending flag stays set.
- R6: A pending window that was held by protect commits all its registers at the first vsync after protect falls, while the request stays armed in between.
- R7: A write in the same cycle as a committing vsync leaves the previous shadow value in the active copy. The new value stays pending.
- R8: `win_enable[w]` equals bit 0 of active register 0 of window w, so a shadow change of that bit takes effect only at the committing vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_addr | input | ADDR_W | MSB selects control word; else {window, register index} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Shadow register or control word at cpu_addr |
| vsync | input | 1 | Frame boundary pulse |
| win_protect | input | NUM_WIN | Per-window hold of the vsync copy |
| active_regs | output | NUM_WIN*REGS_PER_WIN*DATA_W | Active set, window w register r at slice (w*REGS_PER_WIN+r) |
| win_enable | output | NUM_WIN | Active enable bit of each window |

## Verification
The hardest situation to reach is a request that stays armed across several vsyncs because one window is pending under protect, while another window commits. A second hard case is a write landing on the very cycle of the committing vsync. Directed sequences build both: they raise protect on one window, write both windows, arm, and pulse vsync with and without protect. A constrained-random phase then mixes writes, protect toggles, requests and vsyncs, and a behavioural model checks the active set, enables and readback every cycle.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE    = 2'd0,
        UPD_ARMED   = 2'd1,
        UPD_BLOCKED = 2'd2
    } upd_state_t;

    localparam int CTRL_REQ_BIT = 0;
    localparam int ENABLE_BIT   = 0;

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vsb_decode.sv
module vsb_decode #(
    parameter int NUM_WIN = 2,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 2,
    parameter int WIN_W   = 1,
    parameter int ADDR_W  = 4
) (
    input  logic                      cpu_wr,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [NUM_WIN*DATA_W-1:0] win_rd_flat,
    input  logic [NUM_WIN-1:0]        pending,
    input  logic                      armed,
    output logic [NUM_WIN-1:0]        win_wr,
    output logic [IDX_W-1:0]          reg_idx,
    output logic                      req_set,
    output logic [DATA_W-1:0]         cpu_rdata
);
    import vsb_pkg::*;

    logic             is_ctrl;
    logic [WIN_W-1:0] win_sel;
    logic [DATA_W-1:0] ctrl_word;

    assign is_ctrl = cpu_addr[ADDR_W-1];
    assign win_sel = cpu_addr[IDX_W +: WIN_W];
    assign reg_idx = cpu_addr[IDX_W-1:0];
    assign req_set = cpu_wr && is_ctrl && cpu_wdata[CTRL_REQ_BIT];
    assign ctrl_word = DATA_W'({pending, armed});

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_wsel
        assign win_wr[w] = cpu_wr && !is_ctrl && (win_sel == WIN_W'(w));
    end

    always_comb begin
        cpu_rdata = '0;
        if (is_ctrl) begin
            cpu_rdata = ctrl_word;
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (win_sel == WIN_W'(w)) begin
                    cpu_rdata = win_rd_flat[w*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/vsb_window.sv
module vsb_window #(
    parameter int DATA_W = 32,
    parameter int REGS   = 4,
    parameter int IDX_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   commit,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   pending,
    output logic [REGS*DATA_W-1:0] active_flat,
    output logic                   enable
);
    import vsb_pkg::*;

    logic [DATA_W-1:0] shadow_q [REGS];
    logic [DATA_W-1:0] active_q [REGS];

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                shadow_q[r] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active_q[r] <= '0;
            end else if (commit) begin
                active_q[r] <= shadow_q[r];
            end
        end

        assign active_flat[r*DATA_W +: DATA_W] = active_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wr_en) begin
            pending <= 1'b1;
        end else if (commit) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < REGS; r++) begin
            if (rd_idx == IDX_W'(r)) begin
                rd_data = shadow_q[r];
            end
        end
    end

    assign enable = active_q[0][ENABLE_BIT];
endmodule

// File: rtl/vsb_update_fsm.sv
module vsb_update_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic vsync,
    input  logic blocked,
    output logic armed,
    output logic copy_go
);
    import vsb_pkg::*;

    upd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UPD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE: begin
                if (req_set) state_d = UPD_ARMED;
            end
            UPD_ARMED, UPD_BLOCKED: begin
                if (vsync) begin
                    if (req_set)      state_d = UPD_ARMED;
                    else if (blocked) state_d = UPD_BLOCKED;
                    else              state_d = UPD_IDLE;
                end
            end
            default: state_d = UPD_IDLE;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        copy_go = 1'b0;
        unique case (state_q)
            UPD_IDLE: begin
                armed = 1'b0;
            end
            UPD_ARMED, UPD_BLOCKED: begin
                armed   = 1'b1;
                copy_go = vsync;
            end
            default: begin
                armed = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
    parameter int NUM_WIN     = 2,
    parameter int REGS_PER_WIN = 4,
    parameter int DATA_W      = 32,
    localparam int IDX_W      = vsb_pkg::safe_clog2(REGS_PER_WIN),
    localparam int WIN_W      = vsb_pkg::safe_clog2(NUM_WIN),
    localparam int ADDR_W     = IDX_W + WIN_W + 1,
    localparam int ACT_W      = NUM_WIN * REGS_PER_WIN * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               vsync,
    input  logic [NUM_WIN-1:0] win_protect,
    output logic [ACT_W-1:0]   active_regs,
    output logic [NUM_WIN-1:0] win_enable
);
    localparam int WIN_ACT_W = REGS_PER_WIN * DATA_W;

    logic [NUM_WIN-1:0]        win_wr;
    logic [IDX_W-1:0]          reg_idx;
    logic                      req_set;
    logic [NUM_WIN*DATA_W-1:0] win_rd_flat;
    logic [NUM_WIN-1:0]        pending;
    logic [NUM_WIN-1:0]        commit;
    logic                      armed;
    logic                      copy_go;
    logic                      blocked;

    assign blocked = |(pending & win_protect);

    vsb_decode #(
        .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .WIN_W(WIN_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .win_rd_flat(win_rd_flat),
        .pending    (pending),
        .armed      (armed),
        .win_wr     (win_wr),
        .reg_idx    (reg_idx),
        .req_set    (req_set),
        .cpu_rdata  (cpu_rdata)
    );

    vsb_update_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_set(req_set),
        .vsync  (vsync),
        .blocked(blocked),
        .armed  (armed),
        .copy_go(copy_go)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign commit[w] = copy_go && pending[w] && !win_protect[w];

        vsb_window #(
            .DATA_W(DATA_W), .REGS(REGS_PER_WIN), .IDX_W(IDX_W)
        ) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (win_wr[w]),
            .wr_idx     (reg_idx),
            .wr_data    (cpu_wdata),
            .commit     (commit[w]),
            .rd_idx     (reg_idx),
            .rd_data    (win_rd_flat[w*DATA_W +: DATA_W]),
            .pending    (pending[w]),
            .active_flat(active_regs[w*WIN_ACT_W +: WIN_ACT_W]),
            .enable     (win_enable[w])
        );
    end
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker #(
    parameter int NUM_WIN = 2,
    parameter int ACT_W   = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vsync,
    input logic [NUM_WIN-1:0] win_protect,
    input logic [NUM_WIN-1:0] pending,
    input logic               armed,
    input logic               req_set,
    input logic [ACT_W-1:0]   active_regs,
    input logic [NUM_WIN-1:0] win_enable
);
    localparam int SLICE = ACT_W / NUM_WIN;

    AST_ACTIVE_HOLDS_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(active_regs)); // R3
    AST_NO_COPY_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(active_regs)); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !vsync) |=> armed); // R4
    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && vsync && !(|(pending & win_protect)) && !req_set) |=> !armed); // R4
    AST_BLOCKED_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && |(pending & win_protect)) |=> armed); // R6
    AST_ENABLE_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(win_enable)); // R8

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
        AST_PROTECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
            win_protect[w] |=> $stable(active_regs[w*SLICE +: SLICE])); // R5
        AST_PROTECT_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (win_protect[w] && pending[w]) |=> pending[w]); // R5
    end
endmodule

bind vsync_shadow_bank vsb_checker #(
    .NUM_WIN(NUM_WIN),
    .ACT_W  (ACT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .win_protect(win_protect),
    .pending    (pending),
    .armed      (armed),
    .req_set    (req_set),
    .active_regs(active_regs),
    .win_enable (win_enable)
);

// File: tb/vsync_shadow_bank_tb.sv
`timescale 1ns/1ps
module vsync_shadow_bank_tb;
    localparam int NW = 2;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int AC = NW * NR * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          vsync = 1'b0;
    logic [NW-1:0] win_protect = '0;
    logic [AC-1:0] active_regs;
    logic [NW-1:0] win_enable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    vsync_shadow_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vsync(vsync),
        .win_protect(win_protect), .active_regs(active_regs), .win_enable(win_enable)
    );

    // behavioural reference model
    logic [DW-1:0] m_sh  [NW][NR];
    logic [DW-1:0] m_act [NW][NR];
    bit            m_pend[NW];
    bit            m_arm;

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_pend[w] = 0;
            for (int r = 0; r < NR; r++) begin
                m_sh[w][r] = '0;
                m_act[w][r] = '0;
            end
        end
        m_arm = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit copy, blk;
            bit c [NW];
            int ww, rr;
            copy = vsync && m_arm;
            blk = 0;
            for (int w = 0; w < NW; w++) begin
                c[w] = copy && m_pend[w] && !win_protect[w];
                if (m_pend[w] && win_protect[w]) blk = 1;
            end
            for (int w = 0; w < NW; w++)
                if (c[w]) for (int r = 0; r < NR; r++) m_act[w][r] = m_sh[w][r];
            ww = int'(cpu_addr[2]);
            rr = int'(cpu_addr[1:0]);
            for (int w = 0; w < NW; w++) if (c[w]) m_pend[w] = 0;
            if (cpu_wr && !cpu_addr[3]) begin
                m_sh[ww][rr] = cpu_wdata;
                m_pend[ww] = 1;
            end
            if (cpu_wr && cpu_addr[3] && cpu_wdata[0]) m_arm = 1;
            else if (copy && !blk) m_arm = 0;
        end
    end

    function automatic logic [DW-1:0] exp_read();
        if (cpu_addr[3]) return DW'({m_pend[1], m_pend[0], m_arm});
        return m_sh[int'(cpu_addr[2])][int'(cpu_addr[1:0])];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int w = 0; w < NW; w++) begin
                for (int r = 0; r < NR; r++) begin
                    logic [DW-1:0] a;
                    a = active_regs[(w*NR+r)*DW +: DW];
                    check(a === m_act[w][r], cur_req, $sformatf("active w%0d r%0d", w, r),
                          a, m_act[w][r]);
                end
                check(win_enable[w] === m_act[w][0][0], cur_req, "enable",
                      DW'(win_enable[w]), DW'(m_act[w][0][0]));
            end
            check(cpu_rdata === exp_read(), cur_req, "readback", cpu_rdata, exp_read());
        end
    end

    task automatic step(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit vs);
        @(posedge clk); #1;
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d; vsync = vs;
    endtask

    task automatic idle(input logic [AW-1:0] a);
        step(0, a, '0, 0);
    endtask

    task automatic settle();
        @(negedge clk); #0.5;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired in phase %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        idle(4'h8); settle();
        check(cpu_rdata === '0, "R1", "control word after reset", cpu_rdata, '0);
        check(active_regs === '0, "R1", "active after reset", active_regs[DW-1:0], '0);

        // R2: shadow write, readback, active untouched
        cur_req = "R2";
        step(1, 4'h0, 32'h0000_0001, 0);
        step(1, 4'h1, 32'hA5A5_0001, 0);
        idle(4'h1); settle();
        check(cpu_rdata === 32'hA5A5_0001, "R2", "shadow readback", cpu_rdata, 32'hA5A5_0001);
        check(active_regs[2*DW-1:DW] === '0, "R2", "active before commit",
              active_regs[2*DW-1:DW], '0);

        // R3: vsync without request copies nothing
        cur_req = "R3";
        step(0, 4'h8, '0, 1);
        idle(4'h8); settle();
        check(win_enable === 2'b00, "R3", "enable after unarmed vsync", DW'(win_enable), 0);
        check(cpu_rdata === 32'h2, "R3", "w0 still pending", cpu_rdata, 32'h2);

        // R4 and R8: arm then commit
        cur_req = "R4";
        step(1, 4'h8, 32'h1, 0);
        idle(4'h8); settle();
        check(cpu_rdata === 32'h3, "R4", "armed with w0 pending", cpu_rdata, 32'h3);
        cur_req = "R8";
        step(0, 4'h8, '0, 1);
        idle(4'h8); settle();
        check(win_enable === 2'b01, "R8", "enable after commit", DW'(win_enable), 1);
        check(cpu_rdata === 32'h0, "R4", "request cleared", cpu_rdata, 0);

        // R5: protect w1 while both windows written
        cur_req = "R5";
        win_protect = 2'b10;
        step(1, 4'h4, 32'h0000_0001, 0);
        step(1, 4'h6, 32'hBEEF_0006, 0);
        step(1, 4'h2, 32'h1234_0002, 0);
        step(1, 4'h8, 32'h1, 0);
        step(0, 4'h8, '0, 1);
        idle(4'h8); settle();
        check(cpu_rdata === 32'h5, "R5", "w1 pending, still armed", cpu_rdata, 32'h5);
        check(active_regs[(4+2)*DW +: DW] === '0, "R5", "w1 reg2 held",
              active_regs[(4+2)*DW +: DW], 0);
        check(active_regs[2*DW +: DW] === 32'h1234_0002, "R5", "w0 reg2 committed",
              active_regs[2*DW +: DW], 32'h1234_0002);
        step(0, 4'h8, '0, 1);
        idle(4'h8); settle();
        check(win_enable === 2'b01, "R5", "w1 enable still off", DW'(win_enable), 1);

        // R6: drop protect, next vsync commits w1
        cur_req = "R6";
        @(posedge clk); #1 win_protect = 2'b00;
        idle(4'h8);
        step(0, 4'h8, '0, 1);
        idle(4'h8); settle();
        check(win_enable === 2'b11, "R6", "w1 enabled after unprotect", DW'(win_enable), 3);
        check(active_regs[(4+2)*DW +: DW] === 32'hBEEF_0006, "R6", "w1 reg2 committed",
              active_regs[(4+2)*DW +: DW], 32'hBEEF_0006);
        check(cpu_rdata === 32'h0, "R6", "request cleared", cpu_rdata, 0);

        // R7: write during committing vsync
        cur_req = "R7";
        step(1, 4'h3, 32'h0000_0033, 0);
        step(1, 4'h8, 32'h1, 0);
        step(1, 4'h3, 32'h0000_0077, 1);
        idle(4'h8); settle();
        check(active_regs[3*DW +: DW] === 32'h33, "R7", "old value committed",
              active_regs[3*DW +: DW], 32'h33);
        check(cpu_rdata === 32'h2, "R7", "new value pending, disarmed", cpu_rdata, 32'h2);

        // R4: request with protected pending window plus request at vsync
        cur_req = "R4";
        win_protect = 2'b01;
        step(1, 4'h8, 32'h1, 0);
        step(1, 4'h8, 32'h1, 1);
        idle(4'h8); settle();
        check(cpu_rdata === 32'h3, "R4", "re-armed on vsync", cpu_rdata, 32'h3);
        @(posedge clk); #1 win_protect = 2'b00;

        // random mix
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            bit w, v;
            a = AW'($urandom_range(0, 15));
            w = ($urandom_range(0, 3) == 0);
            v = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 15) == 0) win_protect = NW'($urandom_range(0, 3));
            step(w, a, $urandom, v);
        end
        idle(4'h8); settle();
        finish_run();
    end
endmodule